// File: doc/BRIEF.md
# Receive Self-Test Pattern Checker

This block sits behind a serial receiver. It checks each received 10-bit character against a pattern generated on chip, and it reports the progress of the test as a 3-bit status word. It runs on the character-rate clock. A character is taken only in a cycle where `rx_valid` is high. The block always accepts data and has no ready output, so the sender never sees back-pressure. A cycle with `rx_valid` low is simply a gap in the stream. The control inputs (`bist_ctl`, `pll_locked`) and the status output are plain level signals.

When the 2-bit control field selects checking, the block waits for a start character. When it sees one, it reloads a 10-bit linear-feedback register with a seed and compares every following character with the register's value. The register steps once per matching character. When `SEQ_LEN` characters have matched, the block reports that the run ended well. A mismatch or a loss of receive-PLL lock ends the run, and the block then waits for the next start character. When checking is not selected, the status pins carry the low two bits of the received character instead.

The status triple is ordered as {status bit, data bit 0, data bit 1}. It maps to `status_o[2]`, `status_o[1]` and `status_o[0]` in that order.

Top module: `rx_bist_monitor`

## Requirements
- R1: Checking is active only when `bist_ctl` equals 2'b10. In any other setting, each valid character sets `status_o` to {1'b0, rx_char[0], rx_char[1]} on the next clock, and any run in progress is abandoned.
- R2: While checking and waiting for a start, each valid character other than `START_CHAR` sets `status_o` to 3'b100.
- R3: A valid `START_CHAR` (default 10'h0FA) received while waiting sets `status_o` to 3'b101. It also reloads the expected pattern with `SEED` (default 10'h3FF).
- R4: In a run, the first expected character is `SEED`. Each later expected character e' comes from the previous one e as e' = {e[8:0], e[9]^e[6]}. Every matching character that is not the last sets `status_o` to 3'b000 and 3'b001 in turn, starting with 3'b000.
- R5: The `SEQ_LEN`-th matching character of a run (default 16) sets `status_o` to 3'b010, and the block returns to waiting for a start.
- R6: A valid character that differs from the expected one sets `status_o` to 3'b110, and the block returns to waiting for a start.
- R7: While checking, every clock with `pll_locked` low sets `status_o` to 3'b111, whether or not a character is valid. This code overrides every other code, and the run is abandoned.
- R8: A clock with `rx_valid` low, while checking with lock present, leaves `status_o` and the position in the pattern unchanged.
- R9: While `rst_n` is low, `status_o` is 3'b100 and the block is waiting for a start.
- R10: Every status update appears on the clock edge that takes the character, so it is visible one cycle after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_ctl | input | 2 | Receive self-test control; 2'b10 enables checking |
| rx_char | input | CHAR_W | Received character |
| rx_valid | input | 1 | Qualifies `rx_char` for this cycle |
| pll_locked | input | 1 | Receive PLL lock indication |
| status_o | output | 3 | {status bit, data bit 0, data bit 1} |

## Verification
Each status result is due exactly one clock after the cycle that carries its cause: a character, a lock drop or a mode change. A gap cycle is due to leave the status unchanged at that same point. The bench drives its inputs on the falling edge and advances a behavioural model on the rising edge. It then compares `status_o` with the model on the next falling edge, so every comparison falls on the cycle where the single output register has just taken the result. The transmit side is modelled as a reference pattern generator, and it feeds full runs, runs with gaps, corrupted characters and lock drops.

// File: rtl/bistmon_pkg.sv
package bistmon_pkg;
  localparam logic [2:0] CODE_CMP_A  = 3'b000;
  localparam logic [2:0] CODE_CMP_B  = 3'b001;
  localparam logic [2:0] CODE_DONE   = 3'b010;
  localparam logic [2:0] CODE_WAIT   = 3'b100;
  localparam logic [2:0] CODE_START  = 3'b101;
  localparam logic [2:0] CODE_ERROR  = 3'b110;
  localparam logic [2:0] CODE_UNLOCK = 3'b111;

  localparam logic [1:0] CTL_CHECK = 2'b10;

  typedef enum logic {PH_HUNT = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/bistmon_lfsr.sv
module bistmon_lfsr #(
  parameter int unsigned W = 10,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAP_MASK = 10'h240
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  output logic [W-1:0] value
);
  logic [W-1:0] reg_q;
  logic         fb;

  assign fb    = ^(reg_q & TAP_MASK);
  assign value = reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reg_q <= SEED;
    else if (load)    reg_q <= SEED;
    else if (advance) reg_q <= {reg_q[W-2:0], fb};
  end

  // R4: a nonzero seed must never decay into the all-zero lock-up state
  assert_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q != '0);
endmodule

// File: rtl/bistmon_ctrl.sv
module bistmon_ctrl
  import bistmon_pkg::*;
#(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned SEQ_LEN = 16,
  parameter logic [CHAR_W-1:0] START_CHAR = 10'h0FA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bist_ctl,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_valid,
  input  logic              pll_locked,
  input  logic [CHAR_W-1:0] expected,
  output logic              pat_load,
  output logic              pat_adv,
  output logic [2:0]        status_o
);
  localparam int unsigned CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SEQ_LEN - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             alt_q;
  logic [2:0]       stat_q;

  logic in_check, take, is_start, is_match, is_last;

  assign in_check = (bist_ctl == CTL_CHECK);
  assign take     = in_check && pll_locked && rx_valid;
  assign is_start = (rx_char == START_CHAR);
  assign is_match = (rx_char == expected);
  assign is_last  = (cnt_q == LAST_IDX);
  assign pat_load = take && (phase_q == PH_HUNT) && is_start;
  assign pat_adv  = take && (phase_q == PH_RUN) && is_match && !is_last;
  assign status_o = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HUNT;
      cnt_q   <= '0;
      alt_q   <= 1'b0;
      stat_q  <= CODE_WAIT;
    end else if (!in_check) begin
      phase_q <= PH_HUNT;
      if (rx_valid) stat_q <= {1'b0, rx_char[0], rx_char[1]};
    end else if (!pll_locked) begin
      phase_q <= PH_HUNT;
      stat_q  <= CODE_UNLOCK;
    end else if (rx_valid) begin
      if (phase_q == PH_HUNT) begin
        if (is_start) begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
          alt_q   <= 1'b0;
          stat_q  <= CODE_START;
        end else begin
          stat_q  <= CODE_WAIT;
        end
      end else if (!is_match) begin
        phase_q <= PH_HUNT;
        stat_q  <= CODE_ERROR;
      end else if (is_last) begin
        phase_q <= PH_HUNT;
        stat_q  <= CODE_DONE;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        alt_q   <= ~alt_q;
        stat_q  <= alt_q ? CODE_CMP_B : CODE_CMP_A;
      end
    end
  end

  // R7: lock loss while checking wins over every other code
  assert_unlock_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && !pll_locked) |=> (status_o == CODE_UNLOCK));
  // R1: outside check mode the pins carry character bits 0 and 1
  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_check && rx_valid) |=> (status_o == {1'b0, $past(rx_char[0]), $past(rx_char[1])}));
  // R8: a gap cycle changes nothing visible
  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && pll_locked && !rx_valid) |=> $stable(status_o));
  // R6: a character differing from the generator output is flagged
  assert_mismatch_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && phase_q == PH_RUN && rx_char != expected) |=> (status_o == CODE_ERROR));
  // R3: a start character seen while hunting is reported
  assert_start_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && phase_q == PH_HUNT && rx_char == START_CHAR) |=> (status_o == CODE_START));
endmodule

// File: rtl/rx_bist_monitor.sv
module rx_bist_monitor #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned SEQ_LEN = 16,
  parameter logic [CHAR_W-1:0] START_CHAR = 10'h0FA,
  parameter logic [CHAR_W-1:0] SEED = 10'h3FF,
  parameter logic [CHAR_W-1:0] TAP_MASK = 10'h240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bist_ctl,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_valid,
  input  logic              pll_locked,
  output logic [2:0]        status_o
);
  logic [CHAR_W-1:0] expected;
  logic              pat_load;
  logic              pat_adv;

  bistmon_lfsr #(.W(CHAR_W), .SEED(SEED), .TAP_MASK(TAP_MASK)) pat_i (
    .clk(clk), .rst_n(rst_n), .load(pat_load), .advance(pat_adv), .value(expected)
  );

  bistmon_ctrl #(.CHAR_W(CHAR_W), .SEQ_LEN(SEQ_LEN), .START_CHAR(START_CHAR)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .bist_ctl(bist_ctl), .rx_char(rx_char),
    .rx_valid(rx_valid), .pll_locked(pll_locked), .expected(expected),
    .pat_load(pat_load), .pat_adv(pat_adv), .status_o(status_o)
  );
endmodule

// File: tb/rx_bist_monitor_tb_top.sv
module rx_bist_monitor_tb_top;
  localparam int SEQ_LEN = 16;
  localparam logic [9:0] START = 10'h0FA;
  localparam logic [9:0] SEED  = 10'h3FF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bist_ctl = 2'b00;
  logic [9:0] rx_char = '0;
  logic       rx_valid = 1'b0;
  logic       pll_locked = 1'b1;
  logic [2:0] status_o;

  int vectors = 0;
  int misses = 0;

  always #10 clk = ~clk;

  rx_bist_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .bist_ctl(bist_ctl), .rx_char(rx_char),
    .rx_valid(rx_valid), .pll_locked(pll_locked), .status_o(status_o)
  );

  // behavioural reference model
  int         m_run;
  int         m_cnt;
  int         m_alt;
  logic [9:0] m_exp;
  logic [2:0] m_stat;
  string      m_tag;

  function automatic logic [9:0] nxt(input logic [9:0] e);
    return {e[8:0], e[9] ^ e[6]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_stat = 3'b100; m_tag = "R9";
    end else if (bist_ctl != 2'b10) begin
      m_run = 0; m_tag = "R1";
      if (rx_valid) m_stat = {1'b0, rx_char[0], rx_char[1]};
    end else if (!pll_locked) begin
      m_run = 0; m_stat = 3'b111; m_tag = "R7";
    end else if (!rx_valid) begin
      m_tag = "R8";
    end else if (m_run == 0) begin
      if (rx_char == START) begin
        m_run = 1; m_cnt = 0; m_alt = 0; m_exp = SEED; m_stat = 3'b101; m_tag = "R3";
      end else begin
        m_stat = 3'b100; m_tag = "R2";
      end
    end else if (rx_char != m_exp) begin
      m_run = 0; m_stat = 3'b110; m_tag = "R6";
    end else begin
      m_cnt++;
      m_exp = nxt(m_exp);
      if (m_cnt == SEQ_LEN) begin
        m_run = 0; m_stat = 3'b010; m_tag = "R5";
      end else begin
        m_stat = {2'b00, m_alt[0]}; m_alt = 1 - m_alt; m_tag = "R4";
      end
    end
  end

  // one cycle: drive after a falling edge, check at the next falling edge (R10)
  task automatic step(input logic v, input logic [9:0] ch);
    rx_valid = v;
    rx_char  = ch;
    @(negedge clk);
    vectors++;
    if (status_o !== m_stat) begin
      misses++;
      $display("FAIL %s (R10 timing) status_o=%b expected=%b at %0t", m_tag, status_o, m_stat, $time);
    end
  endtask

  function automatic logic [9:0] noise(input int i);
    logic [9:0] c = 10'((i * 37 + 5) & 10'h3FF);
    return (c == START) ? 10'h155 : c;
  endfunction

  // reference transmit side: start, n good characters, optional corruption
  task automatic send_run(input int n, input int bad_at, input int gap_every);
    logic [9:0] g = SEED;
    step(1'b1, START);
    for (int k = 0; k < n; k++) begin
      if (gap_every > 0 && (k % gap_every) == 1) step(1'b0, 10'h2AA);
      step(1'b1, (k == bad_at) ? (g ^ 10'h001) : g);
      g = nxt(g);
    end
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 10'h0FA);              // R9 held in reset
    step(1'b0, 10'h000);
    rst_n = 1'b1;
    // R1 pass-through in each non-check setting
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      bist_ctl = 2'(s);
      for (int i = 0; i < 6; i++) step(1'b1, noise(i + s * 7));
      step(1'b0, 10'h3FF);
      step(1'b1, START);
    end
    bist_ctl = 2'b10;
    for (int i = 0; i < 5; i++) step(1'b1, noise(i + 40));   // R2
    send_run(SEQ_LEN, -1, 0);          // R3 R4 R5
    step(1'b1, noise(3));
    send_run(SEQ_LEN, -1, 3);          // R8 gaps mid-run
    send_run(SEQ_LEN, 5, 0);           // R6 error, then remaining chars hunt
    send_run(SEQ_LEN, 0, 0);           // R6 on first compare
    send_run(SEQ_LEN, SEQ_LEN - 1, 0); // R6 on last character
    // R7 lock loss mid-run, with and without valid
    step(1'b1, START);
    step(1'b1, SEED);
    pll_locked = 1'b0;
    step(1'b1, nxt(SEED));
    step(1'b0, 10'h000);
    pll_locked = 1'b1;
    step(1'b1, nxt(nxt(SEED)));        // back to hunting: R2
    send_run(SEQ_LEN, -1, 0);
    // R1 leaving check mode mid-run abandons it
    step(1'b1, START);
    step(1'b1, SEED);
    bist_ctl = 2'b00;
    step(1'b1, nxt(SEED));
    bist_ctl = 2'b10;
    step(1'b1, nxt(nxt(SEED)));
    send_run(SEQ_LEN, -1, 2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule